// File: doc/BRIEF.md
# Composite Video Sync Timing Generator

This block produces the line and frame timing for a progressive, low-resolution video output. A dot counter walks each line through its regions in a fixed order: horizontal sync, a porch, a left border, the active picture, a right border and a final porch. A line counter walks the frame through a serration interval, blank lines, a top border band, the active lines and a bottom border band. Both counters advance only on cycles where the pixel-clock enable is high. Between enable strobes, every output holds its value.

Outputs are active-low horizontal, vertical and composite sync, an active-low display-window strobe, border flags for the side and top/bottom bands, an active-picture flag, and a one-cycle vertical interrupt request. During the first nine lines of each frame the sync pulses are half width. On those lines the composite output also carries a second, equal pulse at mid-line.

With default parameters a line is 520 dots and a frame is 262 lines. Lines are numbered from 1 and dots from 0.

Top module: `sync_timing_gen`

## Requirements
- R1: When `rst_n` is sampled low on a rising edge, the position becomes line 1, dot 0. Counting then restarts from there, so `hsync_n` stays low for dots 0 to 31 and goes high at dot 32 (line 1 is a serration line).
- R2: On lines 10 to 262, `hsync_n` is low for dots 0 to 63 and high for dots 64 to 519. A line is 520 dots.
- R3: On lines 1 to 9, `vsync_n` is low for the whole line and `hsync_n` is low only for dots 0 to 31. On all other lines `vsync_n` is high.
- R4: On lines 1 to 9, `csync_n` is low for dots 0 to 31 and for dots 260 to 291. On all other lines `csync_n` equals `hsync_n`.
- R5: `blank_n` is low for dots 128 to 501 on lines 23 to 262, and high everywhere else.
- R6: `active` is high for dots 154 to 473 on lines 31 to 254, and low everywhere else.
- R7: `hborder` is high on lines 31 to 254 for dots 128 to 153 (26 dots) and dots 474 to 501 (28 dots). It is low everywhere else and never high together with `active`.
- R8: `vborder` is high for dots 128 to 501 on lines 23 to 30 and lines 255 to 262, and low everywhere else.
- R9: `vint` is high for exactly one clock per frame, at line 255, dot 104, which is 40 dots after horizontal sync ends. Between two such positions it pulses exactly once.
- R10: While `pix_en` is low, the position does not advance and the sync, blank and region outputs hold their values.
- R11: After line 262, dot 519, the position wraps to line 1, dot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; one dot per high cycle |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| blank_n | output | 1 | Display-window strobe, low inside borders plus picture |
| hborder | output | 1 | Left or right border on an active line |
| vborder | output | 1 | Window area on a top or bottom border line |
| active | output | 1 | Active picture dot |
| vint | output | 1 | Vertical interrupt request, one-clock pulse |

## Verification
The hardest case to reach from the ports is the single interrupt dot. It lies 255 lines into the frame, about 132,000 enabled cycles after reset, and is only meaningful if it is seen exactly once per frame. The stimulus holds the enable high and walks one full frame plus the wrap. It stops at a sorted list of positions, including the dots just before, at and after the interrupt. Meanwhile it counts every interrupt pulse across the frame. Freezing the enable in the middle of a half-width pulse, and a reset in the middle of a line, are then applied as directed cases.

// File: rtl/sync_pkg.sv
// Shared types for the sync timing generator.
// Assumes: consumers pick fields by name, never by position.
package sync_pkg;

    // Horizontal decode results for one dot position.
    typedef struct packed {
        logic hs_n;     // horizontal sync component
        logic cs_n;     // composite sync, horizontal part
        logic win;      // inside border+picture window
        logic lbord;    // left border dots
        logic rbord;    // right border dots
        logic act;      // active picture dots
        logic irq_dot;  // interrupt dot position
    } hdec_t;

    // Vertical decode results for one line.
    typedef struct packed {
        logic serr;     // serration (vertical sync) line
        logic vis;      // line inside the visible band
        logic act;      // active picture line
        logic irq_line; // line that carries the interrupt
    } vdec_t;

endpackage

// File: rtl/sync_counter.sv
// Wrapping position counter with enable.
// Counts FIRST..LAST, advancing when step is high.
// Assumes: FIRST <= LAST and LAST fits in W bits.
module sync_counter #(
    parameter int unsigned FIRST = 0,
    parameter int unsigned LAST  = 519,
    parameter int unsigned W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         wrap
);

    localparam logic [W-1:0] FIRST_V = W'(FIRST);
    localparam logic [W-1:0] LAST_V  = W'(LAST);

    // Flag the step that leaves the last value.
    assign wrap = step && (count == LAST_V);

    // Advance or wrap on each step; reset to the first value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= FIRST_V;
        else if (step)
            count <= wrap ? FIRST_V : count + 1'b1;
    end

endmodule

// File: rtl/sync_hdecode.sv
// Horizontal region decoder.
// Maps the dot position to sync, window, border, picture and interrupt-dot flags.
// Assumes: the line regions sum to H_TOTAL and 2*SER_W < H_TOTAL.
module sync_hdecode
    import sync_pkg::*;
#(
    parameter int unsigned W         = 10,
    parameter int unsigned H_TOTAL   = 520,
    parameter int unsigned HS_W      = 64,
    parameter int unsigned SER_W     = 32,
    parameter int unsigned WIN_START = 128,
    parameter int unsigned ACT_START = 154,
    parameter int unsigned ACT_END   = 474,
    parameter int unsigned WIN_END   = 502,
    parameter int unsigned IRQ_DOT   = 104
) (
    input  logic [W-1:0] dot,
    input  logic         serr,
    output hdec_t        hd
);

    localparam int unsigned MID = H_TOTAL / 2;

    int unsigned d;
    logic        full_pulse;
    logic        half_pulse;
    logic        mid_pulse;

    // Widen the dot position once for all comparisons.
    assign d = 32'(dot);

    // Decode the pulse windows.
    always_comb begin
        full_pulse = (d < HS_W);
        half_pulse = (d < SER_W);
        mid_pulse  = (d >= MID) && (d < MID + SER_W);
    end

    // Assemble the decoded regions.
    always_comb begin
        hd.hs_n    = serr ? !half_pulse : !full_pulse;
        hd.cs_n    = serr ? !(half_pulse || mid_pulse) : !full_pulse;
        hd.win     = (d >= WIN_START) && (d < WIN_END);
        hd.lbord   = (d >= WIN_START) && (d < ACT_START);
        hd.rbord   = (d >= ACT_END) && (d < WIN_END);
        hd.act     = (d >= ACT_START) && (d < ACT_END);
        hd.irq_dot = (d == IRQ_DOT);
    end

endmodule

// File: rtl/sync_vdecode.sv
// Vertical region decoder.
// Maps the line number to serration, visible band, active band and interrupt line.
// Assumes: lines are numbered from 1 and the bands lie within the frame.
module sync_vdecode
    import sync_pkg::*;
#(
    parameter int unsigned W         = 9,
    parameter int unsigned SER_LINES = 9,
    parameter int unsigned VIS_FIRST = 23,
    parameter int unsigned VIS_LAST  = 262,
    parameter int unsigned ACT_FIRST = 31,
    parameter int unsigned ACT_LAST  = 254,
    parameter int unsigned IRQ_LINE  = 255
) (
    input  logic [W-1:0] line,
    output vdec_t        vd
);

    int unsigned l;

    // Widen the line number once for all comparisons.
    assign l = 32'(line);

    // Decode the vertical bands.
    always_comb begin
        vd.serr     = (l >= 1) && (l <= SER_LINES);
        vd.vis      = (l >= VIS_FIRST) && (l <= VIS_LAST);
        vd.act      = (l >= ACT_FIRST) && (l <= ACT_LAST);
        vd.irq_line = (l == IRQ_LINE);
    end

endmodule

// File: rtl/sync_timing_gen.sv
// Composite video sync timing generator (top).
// Dot and line counters advance on pix_en. The decoders turn the position into
// sync, window, border, picture and interrupt outputs.
// Assumes: pix_en is synchronous to clk; outputs are decoded from the counter registers.
module sync_timing_gen
    import sync_pkg::*;
#(
    parameter int unsigned HS_W      = 64,
    parameter int unsigned SER_W     = 32,
    parameter int unsigned H_FRONT   = 64,
    parameter int unsigned L_BORD    = 26,
    parameter int unsigned ACT_W     = 320,
    parameter int unsigned R_BORD    = 28,
    parameter int unsigned H_BACK    = 18,
    parameter int unsigned IRQ_DELAY = 40,
    parameter int unsigned V_TOTAL   = 262,
    parameter int unsigned SER_LINES = 9,
    parameter int unsigned ACT_FIRST = 31,
    parameter int unsigned ACT_H     = 224,
    parameter int unsigned V_TOP     = 8,
    parameter int unsigned V_BOT     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_en,
    output logic hsync_n,
    output logic vsync_n,
    output logic csync_n,
    output logic blank_n,
    output logic hborder,
    output logic vborder,
    output logic active,
    output logic vint
);

    localparam int unsigned H_TOTAL   = HS_W + H_FRONT + L_BORD + ACT_W + R_BORD + H_BACK;
    localparam int unsigned WIN_START = HS_W + H_FRONT;
    localparam int unsigned ACT_START = WIN_START + L_BORD;
    localparam int unsigned ACT_END   = ACT_START + ACT_W;
    localparam int unsigned WIN_END   = ACT_END + R_BORD;
    localparam int unsigned IRQ_DOT   = HS_W + IRQ_DELAY;
    localparam int unsigned ACT_LAST  = ACT_FIRST + ACT_H - 1;
    localparam int unsigned VIS_FIRST = ACT_FIRST - V_TOP;
    localparam int unsigned VIS_LAST  = ACT_LAST + V_BOT;
    localparam int unsigned IRQ_LINE  = ACT_LAST + 1;
    localparam int unsigned HW        = $clog2(H_TOTAL);
    localparam int unsigned VW        = $clog2(V_TOTAL + 1);

    logic [HW-1:0] dot;
    logic [VW-1:0] line;
    logic          line_end;
    logic          frame_end;
    hdec_t         hd;
    vdec_t         vd;

    // Dot position within the line.
    sync_counter #(.FIRST(0), .LAST(H_TOTAL - 1), .W(HW)) u_dot (
        .clk(clk), .rst_n(rst_n), .step(pix_en), .count(dot), .wrap(line_end)
    );

    // Line number within the frame, advanced at each line end.
    sync_counter #(.FIRST(1), .LAST(V_TOTAL), .W(VW)) u_line (
        .clk(clk), .rst_n(rst_n), .step(line_end), .count(line), .wrap(frame_end)
    );

    sync_hdecode #(
        .W(HW), .H_TOTAL(H_TOTAL), .HS_W(HS_W), .SER_W(SER_W),
        .WIN_START(WIN_START), .ACT_START(ACT_START), .ACT_END(ACT_END),
        .WIN_END(WIN_END), .IRQ_DOT(IRQ_DOT)
    ) u_hdec (
        .dot(dot), .serr(vd.serr), .hd(hd)
    );

    sync_vdecode #(
        .W(VW), .SER_LINES(SER_LINES), .VIS_FIRST(VIS_FIRST), .VIS_LAST(VIS_LAST),
        .ACT_FIRST(ACT_FIRST), .ACT_LAST(ACT_LAST), .IRQ_LINE(IRQ_LINE)
    ) u_vdec (
        .line(line), .vd(vd)
    );

    // Combine the horizontal and vertical decodes into the outputs.
    always_comb begin
        hsync_n = hd.hs_n;
        vsync_n = !vd.serr;
        csync_n = hd.cs_n;
        blank_n = !(vd.vis && hd.win);
        active  = vd.act && hd.act;
        hborder = vd.act && (hd.lbord || hd.rbord);
        vborder = vd.vis && !vd.act && hd.win;
        vint    = pix_en && vd.irq_line && hd.irq_dot;
    end

    // frame_end is only consumed for completeness of the counter interface.
    logic unused_ok;
    assign unused_ok = frame_end;

endmodule

// File: rtl/sync_timing_chk.sv
// Assertion checker for sync_timing_gen, attached by bind.
// Observes the top-level ports only.
module sync_timing_chk #(
    parameter int unsigned HS_W  = 64,
    parameter int unsigned SER_W = 32
) (
    input logic clk,
    input logic rst_n,
    input logic pix_en,
    input logic hsync_n,
    input logic vsync_n,
    input logic csync_n,
    input logic blank_n,
    input logic hborder,
    input logic vborder,
    input logic active,
    input logic vint
);

    logic [15:0] low_cnt;

    // Count enabled cycles spent with hsync low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (hsync_n)
            low_cnt <= '0;
        else if (pix_en)
            low_cnt <= low_cnt + 1'b1;
    end

    // R2 / R3: every horizontal pulse is either full or half width.
    assert_hsync_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (32'(low_cnt) == HS_W || 32'(low_cnt) == SER_W));

    // R4: outside serration lines composite sync follows horizontal sync.
    assert_csync_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_n |-> (csync_n == hsync_n));

    // R6: picture dots only appear inside the display window.
    assert_active_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !blank_n);

    // R7: border flags never overlap the picture.
    assert_border_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !(hborder || vborder));

    // R9: the interrupt request lasts a single clock.
    assert_vint_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vint |=> !vint);

    // R10: outputs hold while the enable is low.
    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable(hsync_n) && $stable(vsync_n) && $stable(csync_n) &&
                     $stable(blank_n) && $stable(active) && $stable(hborder) &&
                     $stable(vborder)));

endmodule

bind sync_timing_gen sync_timing_chk #(.HS_W(HS_W), .SER_W(SER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .csync_n(csync_n),
    .blank_n(blank_n), .hborder(hborder), .vborder(vborder),
    .active(active), .vint(vint)
);

// File: tb/tb_sync_timing_gen.sv
`timescale 1ns/1ps
// Bench for sync_timing_gen: walks one frame through a sorted vector table,
// then runs directed freeze and reset cases.
module tb_sync_timing_gen;

    localparam int H_TOT = 520;
    localparam int V_TOT = 262;
    localparam int NVEC  = 30;

    // {line[8:0], dot[9:0], exp{hs,vs,cs,bl,hb,vb,act,vint}}
    localparam logic [26:0] VEC [NVEC] = '{
        {9'd1,   10'd0,   8'b00010000},
        {9'd1,   10'd31,  8'b00010000},
        {9'd1,   10'd32,  8'b10110000},
        {9'd1,   10'd259, 8'b10110000},
        {9'd1,   10'd260, 8'b10010000},
        {9'd1,   10'd291, 8'b10010000},
        {9'd1,   10'd292, 8'b10110000},
        {9'd9,   10'd40,  8'b10110000},
        {9'd10,  10'd40,  8'b01010000},
        {9'd10,  10'd63,  8'b01010000},
        {9'd10,  10'd64,  8'b11110000},
        {9'd10,  10'd260, 8'b11110000},
        {9'd22,  10'd200, 8'b11110000},
        {9'd23,  10'd127, 8'b11110000},
        {9'd23,  10'd128, 8'b11100100},
        {9'd23,  10'd501, 8'b11100100},
        {9'd23,  10'd502, 8'b11110000},
        {9'd31,  10'd128, 8'b11101000},
        {9'd31,  10'd153, 8'b11101000},
        {9'd31,  10'd154, 8'b11100010},
        {9'd31,  10'd473, 8'b11100010},
        {9'd31,  10'd474, 8'b11101000},
        {9'd31,  10'd501, 8'b11101000},
        {9'd254, 10'd300, 8'b11100010},
        {9'd255, 10'd103, 8'b11110000},
        {9'd255, 10'd104, 8'b11110001},
        {9'd255, 10'd105, 8'b11110000},
        {9'd255, 10'd200, 8'b11100100},
        {9'd262, 10'd519, 8'b11110000},
        {9'd1,   10'd0,   8'b00010000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b0;
    logic hsync_n, vsync_n, csync_n, blank_n, hborder, vborder, active, vint;

    int total = 0;
    int bad = 0;
    int m_line = 1;
    int m_dot = 0;
    int vint_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sync_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .csync_n(csync_n),
        .blank_n(blank_n), .hborder(hborder), .vborder(vborder),
        .active(active), .vint(vint)
    );

    task automatic check(input string req, input logic act_v, input logic exp_v);
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s line=%0d dot=%0d actual=%b expected=%b",
                     req, m_line, m_dot, act_v, exp_v);
        end
    endtask

    // One enabled clock: the model follows the requirement position rules.
    task automatic step();
        @(posedge clk);
        if (pix_en) begin
            if (m_dot == H_TOT - 1) begin
                m_dot = 0;
                m_line = (m_line == V_TOT) ? 1 : m_line + 1;  // R11 wrap
            end else begin
                m_dot++;
            end
        end
        @(negedge clk);
        if (vint) vint_seen++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog line=%0d dot=%0d actual=hung expected=done", m_line, m_dot);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset hsync", hsync_n, 1'b0);
        check("R1 reset vsync", vsync_n, 1'b0);
        check("R1 reset blank", blank_n, 1'b1);
        pix_en = 1'b1;

        // Vector walk over one frame and the wrap
        for (int i = 0; i < NVEC; i++) begin
            logic [26:0] v;
            int tl;
            int td;
            v = VEC[i];
            tl = int'(v[26:18]);
            td = int'(v[17:8]);
            while (m_line != tl || m_dot != td) step();
            check("R2 hsync_n",  hsync_n, v[7]);
            check("R3 vsync_n",  vsync_n, v[6]);
            check("R4 csync_n",  csync_n, v[5]);
            check("R5 blank_n",  blank_n, v[4]);
            check("R7 hborder",  hborder, v[3]);
            check("R8 vborder",  vborder, v[2]);
            check("R6 active",   active,  v[1]);
            check("R9 vint",     vint,    v[0]);
            if (i == NVEC - 1) check("R11 wrap to line 1", vsync_n, 1'b0);
        end

        // R9: exactly one interrupt across the frame
        total++;
        if (vint_seen != 1) begin
            bad++;
            $display("FAIL R9 pulse count actual=%0d expected=1", vint_seen);
        end

        // R10: freeze in the middle of the half-width pulse
        repeat (31) step();
        pix_en = 1'b0;
        repeat (40) @(negedge clk);
        check("R10 frozen hsync", hsync_n, 1'b0);
        check("R10 frozen csync", csync_n, 1'b0);
        pix_en = 1'b1;
        step();
        check("R10 resumes at dot 32", hsync_n, 1'b1);

        // R1: reset in mid-line restarts at line 1 dot 0
        repeat (13) step();
        check("R1 before reset", hsync_n, 1'b1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_line = 1;
        m_dot = 0;
        check("R1 after reset dot0", hsync_n, 1'b0);
        repeat (31) step();
        check("R1 dot31 still low", hsync_n, 1'b0);
        step();
        check("R1 dot32 high", hsync_n, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule